// File: doc/BRIEF.md
# Serial Transmitter with Sixteenth-Bit Stop Control

This block is the transmit half of an asynchronous serial channel. A processor pushes characters into a small queue; the transmitter takes them one at a time into a shift register and sends each as a low start bit, then 5 to 8 data bits least significant bit first, then an optional parity bit, then a high stop period. Every bit time is sixteen pulses of a 16X baud enable supplied from outside. The stop period can be set in sixteenth-bit steps, so a link can be tuned close to a receiver's minimum stop requirement.

Two status flags are produced. The ready flag tells the processor that the queue is filled below a programmed trigger level. The empty flag tells it that the queue is empty and no frame is in progress. Character length, parity and stop length are sampled when a character is loaded into the shift register.

Top module: `serial_tx_fracstop`

## Requirements
- R1: Out of reset, and whenever no frame is in progress, `txd` is high; after reset `tx_empty` is 1.
- R2: A frame begins with 16 ticks low, then each data bit for 16 ticks, least significant bit first; `char_len` 00, 01, 10, 11 selects 5, 6, 7, 8 data bits, and `txd` changes only on clock edges where `tick16` is high.
- R3: With `parity_en` set, one parity bit of 16 ticks follows the data; with `parity_odd` 0 the data bits plus parity hold an even count of ones, with `parity_odd` 1 an odd count.
- R4: The stop period lasts 9+code ticks for `stop_code` 0 to 7 and 17+code ticks for `stop_code` 8 to 15 (0.5625 to 1.0 and 1.5625 to 2.0 bit times).
- R5: When the queue holds a character and `tx_enable` is high at the end of the stop period, the next start bit begins on the very next tick.
- R6: The queue holds DEPTH characters and sends them in write order; a write while it is full is discarded and leaves the stored characters intact.
- R7: While `tx_enable` is low, no new character is started and queued characters stay queued.
- R8: `tx_ready` is 1 exactly when the queue occupancy is below `trig_level`.
- R9: `tx_empty` is 1 exactly when the queue is empty and no frame (including its stop period) is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Push `wr_data` into the queue |
| wr_data | input | 8 | Character to queue |
| tx_enable | input | 1 | Allows new characters to start |
| char_len | input | 2 | Data bits: 00=5, 01=6, 10=7, 11=8 |
| parity_en | input | 1 | Append a parity bit |
| parity_odd | input | 1 | 0 = even parity, 1 = odd parity |
| stop_code | input | 4 | Stop length code |
| trig_level | input | CNT_W | Ready threshold on queue occupancy |
| tick16 | input | 1 | 16X baud enable, one clock wide |
| txd | output | 1 | Serial output |
| tx_ready | output | 1 | Occupancy below `trig_level` |
| tx_empty | output | 1 | Queue empty and line idle |

## Verification
The exact stop length can only be measured from the ports when a second character starts right behind the first, because an idle line after the last stop looks the same as a longer stop. The stimulus therefore fills the queue while the transmitter is disabled and then enables it, so every frame but the last runs back to back and the high run between frames equals the stop count. The same disabled-fill step gives exact control of occupancy for the trigger-level checks and for pushing past a full queue, and a tick-sampled decoder recovers data, parity and stop runs for directed range edges (codes 0, 7, 8, 15) and seeded random settings.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int CHAR_W = 8;
    localparam int TCNT_W = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    // Stop period in 16X ticks: low range 9..16, high range 25..32.
    function automatic logic [TCNT_W-1:0] stop_ticks(input logic [3:0] code);
        logic [TCNT_W-1:0] base;
        base = code[3] ? TCNT_W'(17) : TCNT_W'(9);
        return base + TCNT_W'(code);
    endfunction

endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
    parameter  int DEPTH = 8,
    parameter  int W     = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     rdata,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t   st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic       do_push, do_pop;

    assign full  = (st_q.cnt == CNT_W'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign count = st_q.cnt;
    assign rdata = mem[st_q.rd];

    always_comb begin
        st_d    = st_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) st_d.wr = st_q.wr + 1'b1;
        if (do_pop)  st_d.rd = st_q.rd + 1'b1;
        if (do_push && !do_pop)      st_d.cnt = st_q.cnt + 1'b1;
        else if (do_pop && !do_push) st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wr] <= wdata;
    end

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              tx_enable,
    input  logic              have_char,
    input  logic [CHAR_W-1:0] char_in,
    input  logic [1:0]        char_len,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic [3:0]        stop_code,
    output logic              take,
    output logic              txd,
    output logic              idle
);

    typedef struct packed {
        tx_state_e         state;
        logic [TCNT_W-1:0] tcnt;
        logic [2:0]        bidx;
        logic [2:0]        last_bit;
        logic [CHAR_W-1:0] shreg;
        logic              par;
        logic              par_on;
        logic [TCNT_W-1:0] stop_lim;
    } sh_st_t;

    sh_st_t            st_d, st_q;
    logic [CHAR_W-1:0] masked;
    logic [2:0]        len_m1;
    logic              can_load;
    logic              bit_end;

    assign len_m1   = 3'd4 + 3'(char_len);
    assign can_load = tx_enable && have_char;
    assign bit_end  = (st_q.tcnt == TCNT_W'(15));

    always_comb begin
        for (int i = 0; i < CHAR_W; i++) begin
            masked[i] = char_in[i] && (3'(i) <= len_m1);
        end
    end

    always_comb begin
        st_d = st_q;
        take = 1'b0;
        if (tick16) begin
            st_d.tcnt = st_q.tcnt + 1'b1;
            unique case (st_q.state)
                ST_IDLE: st_d.tcnt = '0;
                ST_START: if (bit_end) begin
                    st_d.tcnt  = '0;
                    st_d.state = ST_DATA;
                end
                ST_DATA: if (bit_end) begin
                    st_d.tcnt  = '0;
                    st_d.shreg = st_q.shreg >> 1;
                    st_d.bidx  = st_q.bidx + 1'b1;
                    if (st_q.bidx == st_q.last_bit) begin
                        st_d.bidx  = '0;
                        st_d.state = st_q.par_on ? ST_PAR : ST_STOP;
                    end
                end
                ST_PAR: if (bit_end) begin
                    st_d.tcnt  = '0;
                    st_d.state = ST_STOP;
                end
                ST_STOP: if (st_q.tcnt == st_q.stop_lim - 1'b1) begin
                    st_d.tcnt  = '0;
                    st_d.state = ST_IDLE;
                end
                default: st_d.state = ST_IDLE;
            endcase
            // Load a new character from idle or at the end of a stop period.
            if (can_load && (st_d.state == ST_IDLE)) begin
                take          = 1'b1;
                st_d.state    = ST_START;
                st_d.tcnt     = '0;
                st_d.bidx     = '0;
                st_d.last_bit = len_m1;
                st_d.shreg    = masked;
                st_d.par      = (^masked) ^ parity_odd;
                st_d.par_on   = parity_en;
                st_d.stop_lim = stop_ticks(stop_code);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (st_q.state)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = st_q.shreg[0];
            ST_PAR:   txd = st_q.par;
            default:  txd = 1'b1;
        endcase
    end

    assign idle = (st_q.state == ST_IDLE);

endmodule

// File: rtl/serial_tx_fracstop.sv
module serial_tx_fracstop
    import sertx_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              tx_enable,
    input  logic [1:0]        char_len,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic [3:0]        stop_code,
    input  logic [CNT_W-1:0]  trig_level,
    input  logic              tick16,
    output logic              txd,
    output logic              tx_ready,
    output logic              tx_empty
);

    logic [CHAR_W-1:0] head;
    logic [CNT_W-1:0]  fifo_cnt;
    logic              fifo_full, fifo_empty;
    logic              take;
    logic              sh_idle;

    sertx_fifo #(.DEPTH(DEPTH), .W(CHAR_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wr_en),
        .wdata (wr_data),
        .pop   (take),
        .rdata (head),
        .count (fifo_cnt),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    sertx_shift u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick16     (tick16),
        .tx_enable  (tx_enable),
        .have_char  (!fifo_empty),
        .char_in    (head),
        .char_len   (char_len),
        .parity_en  (parity_en),
        .parity_odd (parity_odd),
        .stop_code  (stop_code),
        .take       (take),
        .txd        (txd),
        .idle       (sh_idle)
    );

    assign tx_ready = (fifo_cnt < trig_level);
    assign tx_empty = fifo_empty && sh_idle;

endmodule

// File: rtl/serial_tx_fracstop_chk.sv
module serial_tx_fracstop_chk #(
    parameter  int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             txd,
    input logic             tx_empty,
    input logic             tx_ready,
    input logic             wr_en,
    input logic             tx_enable,
    input logic             tick16,
    input logic [CNT_W-1:0] trig_level,
    input logic [CNT_W-1:0] occ,
    input logic             line_idle
);

    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> txd);

    assert_txd_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick16 |=> $stable(txd));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH));

    assert_full_write_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CNT_W'(DEPTH) && wr_en) |=> (occ == CNT_W'(DEPTH) || occ == CNT_W'(DEPTH - 1)));

    assert_hold_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (line_idle && !tx_enable) |=> line_idle);

    assert_ready_when_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && trig_level != '0) |-> tx_ready);

    assert_empty_means_no_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> (occ == '0));

endmodule

bind serial_tx_fracstop serial_tx_fracstop_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .txd        (txd),
    .tx_empty   (tx_empty),
    .tx_ready   (tx_ready),
    .wr_en      (wr_en),
    .tx_enable  (tx_enable),
    .tick16     (tick16),
    .trig_level (trig_level),
    .occ        (fifo_cnt),
    .line_idle  (sh_idle)
);

// File: tb/serial_tx_fracstop_tb.sv
module serial_tx_fracstop_tb;

    localparam int DEPTH = 8;
    localparam int CNT_W = $clog2(DEPTH) + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [7:0]       wr_data = '0;
    logic             tx_enable = 1'b0;
    logic [1:0]       char_len = 2'b11;
    logic             parity_en = 1'b0;
    logic             parity_odd = 1'b0;
    logic [3:0]       stop_code = '0;
    logic [CNT_W-1:0] trig_level = CNT_W'(1);
    logic             tick16 = 1'b0;
    logic             txd, tx_ready, tx_empty;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  pending_start = 0;
    bit  done = 0;
    logic [7:0] exp_q[$];

    serial_tx_fracstop #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .tx_enable(tx_enable), .char_len(char_len), .parity_en(parity_en),
        .parity_odd(parity_odd), .stop_code(stop_code), .trig_level(trig_level),
        .tick16(tick16), .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty)
    );

    always #4 clk = ~clk;

    // 16X enable: one clock high, one clock low.
    initial begin
        forever begin
            @(posedge clk);
            #1 tick16 = ~tick16;
        end
    end

    function automatic int exp_stop(input logic [3:0] c);
        return (c < 8) ? 9 + int'(c) : 17 + int'(c);
    endfunction

    function automatic logic [7:0] mask_char(input logic [7:0] v, input logic [1:0] l);
        return v & 8'((9'd1 << (5 + int'(l))) - 1);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic get_sample(output logic v);
        do @(negedge clk); while (tick16 !== 1'b1);
        v = txd;
    endtask

    task automatic write_char(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Decode one frame from tick samples; stop_run is the high run that follows.
    task automatic recv(output logic [7:0] data, output logic pbit, output int stop_run);
        logic v;
        int   nb;
        data = '0;
        pbit = 1'b0;
        if (!pending_start) begin
            do get_sample(v); while (v !== 1'b0);
        end
        pending_start = 0;
        check(tx_empty == 1'b0, "R9 busy during frame", int'(tx_empty), 0);
        for (int i = 1; i < 16; i++) get_sample(v);
        nb = 5 + int'(char_len);
        for (int b = 0; b < nb; b++) begin
            for (int s = 0; s < 16; s++) begin
                get_sample(v);
                if (s == 8) data[b] = v;
            end
        end
        if (parity_en) begin
            for (int s = 0; s < 16; s++) begin
                get_sample(v);
                if (s == 8) pbit = v;
            end
        end
        stop_run = 0;
        forever begin
            get_sample(v);
            if (v === 1'b0) begin
                pending_start = 1;
                break;
            end
            stop_run++;
            if (stop_run == 40) break;
        end
    endtask

    task automatic run_batch(input logic [1:0] l, input bit pe, input bit po,
                             input logic [3:0] code, input int n, input int trig);
        logic [7:0] got, exp;
        logic       pb;
        int         run;
        tx_enable  = 1'b0;
        char_len   = l;
        parity_en  = pe;
        parity_odd = po;
        stop_code  = code;
        trig_level = CNT_W'(trig);
        for (int i = 0; i < n; i++) begin
            logic [7:0] c;
            c = 8'($urandom);
            write_char(c);
            if (exp_q.size() < DEPTH) exp_q.push_back(c);
        end
        check(tx_ready == (exp_q.size() < trig), "R8 ready vs trigger",
              int'(tx_ready), int'(exp_q.size() < trig));
        @(negedge clk);
        tx_enable = 1'b1;
        while (exp_q.size() > 0) begin
            exp = mask_char(exp_q.pop_front(), l);
            recv(got, pb, run);
            check(got == exp, "R2/R6 data bits", int'(got), int'(exp));
            if (pe) check(pb == ((^exp) ^ po), "R3 parity bit", int'(pb), int'((^exp) ^ po));
            if (exp_q.size() > 0)
                check(run == exp_stop(code), "R4/R5 stop ticks back to back", run, exp_stop(code));
            else
                check(run == 40, "R9 line stays idle after last frame", run, 40);
        end
        check(tx_empty == 1'b1, "R9 empty after last stop", int'(tx_empty), 1);
        check(txd == 1'b1, "R1 idle high", int'(txd), 1);
        tx_enable = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic v;
        bit   all_high;
        void'($urandom(32'd1729));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(txd == 1'b1, "R1 txd after reset", int'(txd), 1);
        check(tx_empty == 1'b1, "R1 empty after reset", int'(tx_empty), 1);
        check(tx_ready == 1'b1, "R8 ready with empty queue", int'(tx_ready), 1);

        // Directed: both ranges of the stop code at their edges.
        run_batch(2'b11, 1'b1, 1'b0, 4'd0,  3, 4);
        run_batch(2'b11, 1'b1, 1'b1, 4'd7,  3, 2);
        run_batch(2'b00, 1'b0, 1'b0, 4'd8,  3, 3);
        run_batch(2'b10, 1'b1, 1'b1, 4'd15, 3, 8);
        run_batch(2'b01, 1'b1, 1'b0, 4'd12, 4, 5);

        // R7: queued data waits while disabled.
        tx_enable = 1'b0;
        write_char(8'hA5);
        exp_q.push_back(8'hA5);
        write_char(8'h3C);
        exp_q.push_back(8'h3C);
        all_high = 1;
        for (int i = 0; i < 100; i++) begin
            get_sample(v);
            if (v !== 1'b1) all_high = 0;
        end
        check(all_high, "R7 no start while disabled", int'(all_high), 1);
        check(tx_empty == 1'b0, "R7 characters held", int'(tx_empty), 0);
        run_batch(2'b11, 1'b0, 1'b0, 4'd3, 0, 3);

        // R6: overfill; extra writes dropped, order kept.
        run_batch(2'b11, 1'b1, 1'b0, 4'd9, DEPTH + 3, DEPTH);

        // Random settings with fixed seed.
        for (int k = 0; k < 10; k++) begin
            run_batch(2'($urandom), 1'($urandom), 1'($urandom), 4'($urandom),
                      2 + int'($urandom % (DEPTH - 1)), int'($urandom % (DEPTH + 1)));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule